// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port reached over a simple 32-bit register bus that covers a 4 KB window. The bus carries a word address (byte offset divided by four), a select, a write flag and write data. Read data is registered and appears the cycle after a read access.

The port data register is mirrored across the whole lower 1 KB of the window. The eight word-address bits that select a mirror are used as a per-pin mask, so software can set, clear or sample any subset of pins with a single write or read and no read-modify-write. A direction register chooses which pins the port drives. Input pins are sampled into the data register every clock, and the resolved pad levels leave the block on `pin_out`, where an input pin is reported as high. A registered change vector marks, for one cycle, each pin whose resolved level has just moved. Eight plain pad-control registers and a read-only block of twelve identification bytes fill out the map.

Top module: `maskgpio_port`

## Requirements
- R1: After reset, data and direction are zero, every pad-control register is zero, `pin_out` is 8'hFF, `pin_chg` is zero and `bus_rdata` is zero.
- R2: A read at any word address below 0x100 returns the data register ANDed with word-address bits [7:0] in bits [7:0] and zero in bits [31:8]. `bus_rdata` updates on the edge that takes the read and holds its value until the next read.
- R3: A write at a word address below 0x100 changes only the data bits that are set both in word-address bits [7:0] and in the direction register. All other data bits keep their values.
- R4: The direction register sits at word address 0x100 (byte offset 0x400). A 1 makes the pin an output. Write data bits [7:0] are stored, and a read returns them with bits [31:8] zero.
- R5: Each `pin_out` bit equals the data bit when that pin is an output and is 1 when it is an input.
- R6: On every clock, each data bit whose direction bit is 0 takes the level of its `pin_in` bit. A `pin_in` bit has no effect on a data bit whose direction bit is 1.
- R7: Word addresses 0x3F4 through 0x3FF (byte offsets 0xFD0 to 0xFFC) return one identification byte each, in order 00, 00, 00, 00, 61, 10, 04, 00, 0D, F0, 05, B1, in bits [7:0] with bits [31:8] zero.
- R8: Eight pad-control registers sit at word addresses 0x140 + k, k = 0 to 7 (byte offsets 0x500 to 0x51C): three drive-strength selects, open drain, pull-up, pull-down, slew control and digital enable. Each stores write data bits [7:0] and reads them back with bits [31:8] zero.
- R9: A read of any other word address returns zero. A write to it changes no register.
- R10: `pin_chg` is registered. In the cycle after an edge, each bit is 1 exactly when the matching `pin_out` bit changed at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address (byte offset >> 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Pin levels driven from outside |
| pin_out | output | 8 | Resolved pad levels |
| pin_chg | output | 8 | One-cycle marks of changed pad levels |

## Verification
A write, a pin sample and the resulting `pin_out` and `pin_chg` all take effect on the same clock edge. A read returns the state as it stood before that edge. The bench drives each access on the falling edge and compares every output 1 ns after the following rising edge. It keeps a model that it advances once per cycle, and it compares read data against the model's state from before the update. Outputs are checked on every cycle, not only after directed steps.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;

  parameter int PIN_W   = 8;
  parameter int BUS_W   = 32;
  parameter int WADDR_W = 10;
  parameter int NPAD    = 8;
  parameter int NID     = 12;

  localparam int PADIDX_W = $clog2(NPAD);
  localparam int IDIDX_W  = $clog2(NID);

  localparam logic [WADDR_W-1:0] DIR_WADDR = 10'h100;
  localparam logic [WADDR_W-1:0] PAD_BASE  = 10'h140;
  localparam logic [WADDR_W-1:0] ID_BASE   = 10'h3F4;

  typedef struct packed {
    logic                data;
    logic                dir;
    logic                pad;
    logic                id;
    logic [PADIDX_W-1:0] pad_idx;
    logic [IDIDX_W-1:0]  id_idx;
    logic [PIN_W-1:0]    mask;
  } acc_dec_t;

  function automatic logic [7:0] id_byte(input logic [IDIDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      4'd4:    b = 8'h61;
      4'd5:    b = 8'h10;
      4'd6:    b = 8'h04;
      4'd8:    b = 8'h0D;
      4'd9:    b = 8'hF0;
      4'd10:   b = 8'h05;
      4'd11:   b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/maskgpio_rst_sync.sv
module maskgpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/maskgpio_decode.sv
module maskgpio_decode
  import maskgpio_pkg::*;
#(
  parameter int AW = WADDR_W,
  parameter int PW = PIN_W
) (
  input  logic [AW-1:0] waddr,
  output acc_dec_t      dec
);

  localparam int DATA_TOP = PW;

  logic [AW-1:0] pad_off;
  logic [AW-1:0] id_off;

  always_comb begin
    pad_off      = waddr - PAD_BASE;
    id_off       = waddr - ID_BASE;
    dec          = '0;
    dec.mask     = waddr[PW-1:0];
    dec.data     = (waddr[AW-1:DATA_TOP] == '0);
    dec.dir      = (waddr == DIR_WADDR);
    dec.pad      = (waddr >= PAD_BASE) && (waddr < PAD_BASE + AW'(NPAD));
    dec.id       = (waddr >= ID_BASE);
    dec.pad_idx  = pad_off[PADIDX_W-1:0];
    dec.id_idx   = id_off[IDIDX_W-1:0];
  end

  always_comb begin
    assert ($countones({dec.data, dec.dir, dec.pad, dec.id}) <= 1)
      else $error("AST_DECODE_EXCLUSIVE"); // R9
  end

endmodule

// File: rtl/maskgpio_pin_core.sv
module maskgpio_pin_core #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_dir,
  input  logic [PW-1:0] mask,
  input  logic [PW-1:0] wdata,
  input  logic [PW-1:0] pin_in,
  output logic [PW-1:0] data_q,
  output logic [PW-1:0] dir_q,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_chg
);

  logic [PW-1:0] data_d;
  logic [PW-1:0] dir_d;
  logic          dir_en;
  logic [PW-1:0] wmask;
  logic [PW-1:0] out_d;
  logic [PW-1:0] out_q;
  logic [PW-1:0] chg_d;
  logic [PW-1:0] chg_q;

  always_comb begin
    wmask  = mask & dir_q;
    data_d = (data_q & dir_q) | (pin_in & ~dir_q);
    if (wr_data) data_d = (data_d & ~wmask) | (wdata & wmask);
    dir_en = wr_dir;
    dir_d  = wdata;
    out_d  = (data_d & (dir_en ? dir_d : dir_q)) | ~(dir_en ? dir_d : dir_q);
    chg_d  = out_d ^ out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      out_q  <= '1;
      chg_q  <= '0;
    end else begin
      data_q <= data_d;
      out_q  <= out_d;
      chg_q  <= chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  assign pin_out = out_q;
  assign pin_chg = chg_q;

  AST_INPUT_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out | dir_q) == '1); // R5
  AST_OUTPUT_PIN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & dir_q) == (data_q & dir_q)); // R5
  AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> ((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(mask)) == '0); // R3
  AST_INPUT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_q & ~$past(dir_q)) == ($past(pin_in) & ~$past(dir_q))); // R6
  AST_CHG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pin_chg == (pin_out ^ $past(pin_out))); // R10

endmodule

// File: rtl/maskgpio_pad_bank.sv
module maskgpio_pad_bank #(
  parameter int NREG = 8,
  parameter int RW   = 8,
  parameter int IW   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [IW-1:0]       idx,
  input  logic [RW-1:0]       wdata,
  output logic [NREG-1:0][RW-1:0] regs_q
);

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic          en;
    logic [RW-1:0] nxt;

    always_comb begin
      en  = wr && (idx == IW'(k));
      nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[k] <= '0;
      else if (en) regs_q[k] <= nxt;
    end
  end

  AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(regs_q)); // R8

endmodule

// File: rtl/maskgpio_port.sv
module maskgpio_port
  import maskgpio_pkg::*;
#(
  parameter int PW = PIN_W,
  parameter int DW = BUS_W,
  parameter int AW = WADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [PW-1:0] pin_in,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_chg
);

  logic                    rst_n_i;
  acc_dec_t                dec;
  logic                    wr_acc;
  logic                    rd_acc;
  logic [PW-1:0]           data_q;
  logic [PW-1:0]           dir_q;
  logic [NPAD-1:0][PW-1:0] pad_q;
  logic [DW-1:0]           rd_d;
  logic [DW-1:0]           rdata_q;
  logic                    rd_unmapped;
  logic                    unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:PW];

  maskgpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_i)
  );

  maskgpio_decode #(.AW(AW), .PW(PW)) u_dec (
    .waddr(bus_waddr),
    .dec  (dec)
  );

  assign wr_acc = bus_sel & bus_wr;
  assign rd_acc = bus_sel & ~bus_wr;

  maskgpio_pin_core #(.PW(PW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .wr_data(wr_acc & dec.data),
    .wr_dir (wr_acc & dec.dir),
    .mask   (dec.mask),
    .wdata  (bus_wdata[PW-1:0]),
    .pin_in (pin_in),
    .data_q (data_q),
    .dir_q  (dir_q),
    .pin_out(pin_out),
    .pin_chg(pin_chg)
  );

  maskgpio_pad_bank #(.NREG(NPAD), .RW(PW)) u_pads (
    .clk   (clk),
    .rst_n (rst_n_i),
    .wr    (wr_acc & dec.pad),
    .idx   (dec.pad_idx),
    .wdata (bus_wdata[PW-1:0]),
    .regs_q(pad_q)
  );

  always_comb begin
    rd_d = '0;
    if (dec.data)     rd_d[PW-1:0] = data_q & dec.mask;
    else if (dec.dir) rd_d[PW-1:0] = dir_q;
    else if (dec.pad) rd_d[PW-1:0] = pad_q[dec.pad_idx];
    else if (dec.id)  rd_d[7:0]    = id_byte(dec.id_idx);
    rd_unmapped = ~(dec.data | dec.dir | dec.pad | dec.id);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    rdata_q <= '0;
    else if (rd_acc) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_acc && rd_unmapped) |=> bus_rdata == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_acc |=> $stable(bus_rdata)); // R2
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_rdata[DW-1:PW] == '0); // R4

endmodule

// File: tb/maskgpio_port_tb.sv
module maskgpio_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [9:0]  bus_waddr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_chg;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_data, m_dir, m_out;
  logic [7:0] m_pad [8];

  always #2 clk = ~clk;

  maskgpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_chg(pin_chg)
  );

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                           8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] a);
    if (a < 10'h100)                    return {24'h0, m_data & a[7:0]};
    if (a == 10'h100)                   return {24'h0, m_dir};
    if (a >= 10'h140 && a <= 10'h147)   return {24'h0, m_pad[a - 10'h140]};
    if (a >= 10'h3F4)                   return {24'h0, exp_id(int'(a - 10'h3F4))};
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [9:0] a);
    if (a < 10'h100)                    return "R2";
    if (a == 10'h100)                   return "R4";
    if (a >= 10'h140 && a <= 10'h147)   return "R8";
    if (a >= 10'h3F4)                   return "R7";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic sel, input logic wr, input logic [9:0] a,
                       input logic [31:0] wd, input logic [7:0] pins);
    logic [31:0] rexp;
    logic [7:0]  prev, wm, ndata, ndir;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_waddr = a; bus_wdata = wd; pin_in = pins;
    rexp  = exp_read(a);
    prev  = m_out;
    ndata = (m_data & m_dir) | (pins & ~m_dir);
    ndir  = m_dir;
    if (sel && wr) begin
      if (a < 10'h100) begin
        wm    = a[7:0] & m_dir;
        ndata = (ndata & ~wm) | (wd[7:0] & wm);
      end else if (a == 10'h100) ndir = wd[7:0];
      else if (a >= 10'h140 && a <= 10'h147) m_pad[a - 10'h140] = wd[7:0];
    end
    m_data = ndata;
    m_dir  = ndir;
    m_out  = (m_data & m_dir) | ~m_dir;
    @(posedge clk);
    #1;
    check("R5 pin_out", {24'h0, pin_out}, {24'h0, m_out});
    check("R10 pin_chg", {24'h0, pin_chg}, {24'h0, m_out ^ prev});
    if (sel && !wr) check(tag_of(a), bus_rdata, rexp);
  endtask

  task automatic rd(input logic [9:0] a);
    cycle(1'b1, 1'b0, a, 32'h0, pin_in);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    cycle(1'b1, 1'b1, a, d, pin_in);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0]  a;
    logic [31:0] w;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_waddr = 0; bus_wdata = 0; pin_in = 8'h00;
    m_data = 0; m_dir = 0; m_out = 8'hFF;
    for (int k = 0; k < 8; k++) m_pad[k] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 pin_out", {24'h0, pin_out}, 32'hFF);
    check("R1 pin_chg", {24'h0, pin_chg}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(10'h0FF); rd(10'h100);
    for (int k = 0; k < 8; k++) rd(10'h140 + 10'(k));

    // R6: input pins follow; R2 masked read
    cycle(0, 0, 0, 0, 8'hA5); rd(10'h0FF); rd(10'h00F);
    // R4/R3: make low nibble output, masked writes
    wr(10'h100, 32'hFFFF_FF0F);
    wr(10'h0FF, 32'h0000_00FF);
    wr(10'h003, 32'h0000_0000);
    rd(10'h0FF);
    wr(10'h0F0, 32'h0000_0000);   // R3: mask only hits input bits
    rd(10'h0FF);
    cycle(0, 0, 0, 0, 8'h00); cycle(0, 0, 0, 0, 8'hFF); rd(10'h0FF);  // R6
    // R7 ID area
    for (int k = 0; k < 12; k++) rd(10'h3F4 + 10'(k));
    // R8 pads
    for (int k = 0; k < 8; k++) wr(10'h140 + 10'(k), 32'hABCD_0011 * (k + 1));
    for (int k = 0; k < 8; k++) rd(10'h140 + 10'(k));
    // R9 unmapped writes ignored, reads zero
    wr(10'h101, 32'hFFFF_FFFF); wr(10'h107, 32'h5A); wr(10'h148, 32'h77); wr(10'h3F3, 32'h11);
    rd(10'h101); rd(10'h107); rd(10'h148); rd(10'h3F3); rd(10'h100); rd(10'h0FF);
    for (int k = 0; k < 8; k++) rd(10'h140 + 10'(k));
    // dir to all outputs then inputs: pin_chg pulses (R10)
    wr(10'h100, 32'hFF); wr(10'h0FF, 32'h3C); wr(10'h100, 32'h00); cycle(0, 0, 0, 0, 8'h12);

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 7);
      w = $urandom;
      case (op)
        0: cycle(0, 0, 10'($urandom), w, 8'($urandom));
        1: cycle(1, 1, {2'b00, 8'($urandom)}, w, pin_in);
        2: cycle(1, 0, {2'b00, 8'($urandom)}, w, 8'($urandom));
        3: cycle(1, $urandom_range(0, 1) == 1, 10'h100, w, pin_in);
        4: cycle(1, $urandom_range(0, 1) == 1, 10'h140 + 10'($urandom_range(0, 7)), w, pin_in);
        5: begin
             a = 10'($urandom_range(10'h101, 10'h3F3));
             cycle(1, $urandom_range(0, 1) == 1, a, w, pin_in);
           end
        6: cycle(1, 0, 10'h3F4 + 10'($urandom_range(0, 11)), w, pin_in);
        default: cycle(0, 0, 0, 0, 8'($urandom));
      endcase
    end
    rd(10'h0FF); rd(10'h100);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule